// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

This block plays back a short, software-programmed list of DDR2 initialization commands once it is told to start. The list lives in sixteen slots that are loaded one at a time over a simple write port. Each slot holds an enable flag, a command code, a bank-select value, an address value and a post-command wait in memory clocks. On start the sequencer walks the slots from index 0 upward. It skips disabled slots without spending a cycle. For each enabled slot it drives the command for one clock and then drives NOP for the slot's wait. When the last enabled slot's wait runs out it raises an initialization-done status.

Out of reset the slots hold a complete power-up list, so a bare start performs the usual DDR2 bring-up. The block also sits in front of the memory controller's enable. An enable request is held off until initialization is done, and a ready output also waits for an external calibration-complete flag.

Top module: `ddr2_init_seq`

## Requirements
- R1: A write with `cfg_wr_i` high stores `cfg_data_i` into the slot chosen by `cfg_idx_i`. The slot layout, from LSB up, is: wait in bits 7:0, address in bits 21:8, bank select in bits 24:22, command code in bits 27:25 and enable in bit 28. The next start uses the stored contents.
- R2: After reset, slots 0 to 13 hold an enabled list. It starts with a NOP waiting 106, then a precharge-all (address bit 10 set) waiting 4. Next come three mode writes, each waiting 2: bank 2 with address 0, bank 3 with address 0, and bank 1 with address 0x004. Then bank 0 with address 0x532 waits 200, and a second precharge-all waits 4. Four refreshes follow, each waiting 25. Last come bank 0 with address 0x432, bank 1 with 0x384 and bank 1 with 0x004, each waiting 2. Slots 14 and 15 are disabled.
- R3: Command codes are 0 NOP, 1 precharge-all, 2 mode-register write and 3 refresh. They drive {cs_n, ras_n, cas_n, we_n} as 0111, 0010, 0000 and 0001. An enabled slot's command appears for exactly one clock, with that slot's bank and address values.
- R4: A slot with wait w is followed by w clocks of NOP (0111) before the next command. Consecutive enabled slots therefore issue w+1 clocks apart.
- R5: Disabled slots take no clocks. A wait of 0 puts the next enabled slot's command on the very next clock.
- R6: The first enabled slot's command appears in the clock right after the edge that samples `start_i` high in idle. `busy_o` is high from that clock until the sequence ends.
- R7: `init_done_o` is cleared when a sequence starts. It goes high w+1 clocks after the last enabled command, where w is that slot's wait. A start with no enabled slot raises it on the next clock. It is never high together with `busy_o`.
- R8: `start_i` has no effect while `busy_o` is high. The wait countdown and the command timeline carry on unchanged.
- R9: `ctrl_en_o` is `ctrl_en_req_i` gated by `init_done_o`, so it stays low whenever initialization is incomplete or running.
- R10: `ready_o` is high only when `ctrl_en_o` and `cal_done_i` are both high.
- R11: Reset returns the block to idle: busy and done low, pins 1111, and the R2 list restored.
- R12: While idle, the pins read 1111 (deselect), and bank and address read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Slot write strobe |
| cfg_idx_i | input | IDX_W (4) | Slot index to write |
| cfg_data_i | input | SLOT_W (29) | Slot contents |
| start_i | input | 1 | Start the sequence (sampled in idle only) |
| busy_o | output | 1 | Sequence running |
| init_done_o | output | 1 | Initialization complete |
| ddr_cs_n_o | output | 1 | Chip select, active low |
| ddr_ras_n_o | output | 1 | Row strobe, active low |
| ddr_cas_n_o | output | 1 | Column strobe, active low |
| ddr_we_n_o | output | 1 | Write enable, active low |
| ddr_ba_o | output | BA_W (3) | Bank / mode-register select |
| ddr_addr_o | output | ADDR_W (14) | Address / mode value |
| ctrl_en_req_i | input | 1 | Controller enable request |
| cal_done_i | input | 1 | Calibration complete flag |
| ctrl_en_o | output | 1 | Gated controller enable |
| ready_o | output | 1 | Normal traffic permitted |

## Verification
A wrong slot pointer or a skipped slot shows up at once as a command out of order, or with the wrong bank or address, on the pins. A wrong countdown shifts every later command and the done edge by the same number of clocks. So timing errors are visible at the first command after the fault and add up in the total duration. A done flag that rises early shows up as a controller enable while busy is still high.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_NOP  = 3'd0,
      OP_PREA = 3'd1,
      OP_MRS  = 3'd2,
      OP_REF  = 3'd3
   } op_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } pins_t;

   localparam pins_t PINS_IDLE = 4'b1111;
   localparam pins_t PINS_NOP  = 4'b0111;

   function automatic pins_t pins_for(logic [OP_W-1:0] op);
      pins_t p;
      case (op)
         OP_PREA: p = 4'b0010;
         OP_MRS:  p = 4'b0000;
         OP_REF:  p = 4'b0001;
         default: p = PINS_NOP;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/ddr2_init_slots.sv
module ddr2_init_slots
   import ddr2_init_pkg::*;
#(
   parameter int SLOTS  = 16,
   parameter int ADDR_W = 14,
   parameter int BA_W   = 3,
   parameter int WAIT_W = 8,
   parameter logic [ADDR_W-1:0] MR_VAL  = 14'h0432,
   parameter logic [ADDR_W-1:0] EMR_VAL = 14'h0004,
   localparam int IDX_W  = $clog2(SLOTS),
   localparam int SLOT_W = WAIT_W + ADDR_W + BA_W + OP_W + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [SLOT_W-1:0] data_i,
   output logic [SLOT_W-1:0] slot_o [SLOTS],
   output logic [SLOTS-1:0]  en_o
);

   localparam int EN_BIT = SLOT_W - 1;
   localparam logic [ADDR_W-1:0] DLL_RST  = ADDR_W'(32'h100);
   localparam logic [ADDR_W-1:0] OCD_ALL  = ADDR_W'(32'h380);
   localparam logic [ADDR_W-1:0] PRE_ALL  = ADDR_W'(32'h400);

   function automatic logic [SLOT_W-1:0] power_up_slot(int i);
      logic              en;
      logic [OP_W-1:0]   op;
      logic [BA_W-1:0]   ba;
      logic [ADDR_W-1:0] a;
      logic [WAIT_W-1:0] w;
      en = 1'b1;
      op = OP_MRS;
      ba = '0;
      a  = '0;
      w  = WAIT_W'(2);
      case (i)
         0:       begin op = OP_NOP;  w = WAIT_W'(106); end
         1, 6:    begin op = OP_PREA; a = PRE_ALL; w = WAIT_W'(4); end
         2:       ba = BA_W'(2);
         3:       ba = BA_W'(3);
         4:       begin ba = BA_W'(1); a = EMR_VAL & ~OCD_ALL; end
         5:       begin a = MR_VAL | DLL_RST; w = WAIT_W'(200); end
         7, 8, 9, 10: begin op = OP_REF; w = WAIT_W'(25); end
         11:      a = MR_VAL & ~DLL_RST;
         12:      begin ba = BA_W'(1); a = EMR_VAL | OCD_ALL; end
         13:      begin ba = BA_W'(1); a = EMR_VAL & ~OCD_ALL; end
         default: begin en = 1'b0; op = OP_NOP; w = '0; end
      endcase
      return {en, op, ba, a, w};
   endfunction

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [SLOT_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            q <= power_up_slot(g);
         end else if (wr_i && (idx_i == IDX_W'(g))) begin
            q <= data_i;
         end
      end
      assign slot_o[g] = q;
      assign en_o[g]   = q[EN_BIT];
   end

endmodule

// File: rtl/ddr2_init_pick.sv
module ddr2_init_pick #(
   parameter int SLOTS = 16,
   localparam int IDX_W = $clog2(SLOTS)
) (
   input  logic [SLOTS-1:0] en_i,
   input  logic [IDX_W:0]   from_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);

   logic [SLOTS-1:0] cand;

   for (genvar g = 0; g < SLOTS; g++) begin : g_cand
      assign cand[g] = en_i[g] && (from_i <= (IDX_W+1)'(g));
   end

   always_comb begin
      found_o = |cand;
      idx_o   = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (cand[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/ddr2_init_fsm.sv
module ddr2_init_fsm
   import ddr2_init_pkg::*;
#(
   parameter int SLOTS  = 16,
   parameter int ADDR_W = 14,
   parameter int BA_W   = 3,
   parameter int WAIT_W = 8,
   localparam int IDX_W  = $clog2(SLOTS),
   localparam int SLOT_W = WAIT_W + ADDR_W + BA_W + OP_W + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [SLOT_W-1:0] slot_i [SLOTS],
   input  logic [SLOTS-1:0]  en_i,
   output logic              busy_o,
   output logic              done_o,
   output pins_t             pins_o,
   output logic [BA_W-1:0]   ba_o,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int A_LO  = WAIT_W;
   localparam int B_LO  = A_LO + ADDR_W;
   localparam int C_LO  = B_LO + BA_W;

   logic              busy_q, done_q;
   logic [IDX_W-1:0]  cur_q;
   logic [WAIT_W-1:0] cnt_q;
   logic [IDX_W:0]    from;
   logic              found, advance;
   logic [IDX_W-1:0]  nidx;
   logic [SLOT_W-1:0] sel;

   assign from    = busy_q ? ({1'b0, cur_q} + (IDX_W+1)'(1)) : '0;
   assign advance = busy_q ? (cnt_q == '0) : start_i;
   assign sel     = slot_i[nidx];

   ddr2_init_pick #(.SLOTS(SLOTS)) u_pick (
      .en_i   (en_i),
      .from_i (from),
      .found_o(found),
      .idx_o  (nidx)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cur_q  <= '0;
         cnt_q  <= '0;
         pins_o <= PINS_IDLE;
         ba_o   <= '0;
         addr_o <= '0;
      end else if (advance) begin
         if (found) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            cur_q  <= nidx;
            cnt_q  <= sel[WAIT_W-1:0];
            pins_o <= pins_for(sel[C_LO +: OP_W]);
            ba_o   <= sel[B_LO +: BA_W];
            addr_o <= sel[A_LO +: ADDR_W];
         end else begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            pins_o <= PINS_IDLE;
            ba_o   <= '0;
            addr_o <= '0;
         end
      end else if (busy_q) begin
         cnt_q  <= cnt_q - WAIT_W'(1);
         pins_o <= PINS_NOP;
         ba_o   <= '0;
         addr_o <= '0;
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;

   // R3: a real command is only ever on the pins during a run
   assert_cmd_in_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pins_o.cs_n && pins_o != PINS_NOP) |-> busy_q);

   // R4: a pending wait forces NOP on the following clock
   assert_wait_nop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && cnt_q != '0) |=> (pins_o == PINS_NOP));

   // R5: slots are visited in rising index order
   assert_idx_mono_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |=> (!busy_q || cur_q >= $past(cur_q)));

   // R7: done and busy never overlap
   assert_done_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(busy_q && done_q));

   // R8: a start during a wait leaves the countdown running
   assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && cnt_q != '0 && start_i) |=> (busy_q && cnt_q == $past(cnt_q) - WAIT_W'(1)));

   // R12: idle means deselect
   assert_idle_deselect_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_q |-> (pins_o == PINS_IDLE && addr_o == '0));

endmodule

// File: rtl/ddr2_init_gate.sv
module ddr2_init_gate (
   input  logic done_i,
   input  logic req_i,
   input  logic cal_i,
   output logic en_o,
   output logic ready_o
);

   assign en_o    = req_i & done_i;
   assign ready_o = en_o & cal_i;

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
   import ddr2_init_pkg::*;
#(
   parameter int SLOTS  = 16,
   parameter int ADDR_W = 14,
   parameter int BA_W   = 3,
   parameter int WAIT_W = 8,
   parameter logic [ADDR_W-1:0] MR_VAL  = 14'h0432,
   parameter logic [ADDR_W-1:0] EMR_VAL = 14'h0004,
   localparam int IDX_W  = $clog2(SLOTS),
   localparam int SLOT_W = WAIT_W + ADDR_W + BA_W + OP_W + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_wr_i,
   input  logic [IDX_W-1:0]  cfg_idx_i,
   input  logic [SLOT_W-1:0] cfg_data_i,
   input  logic              start_i,
   output logic              busy_o,
   output logic              init_done_o,
   output logic              ddr_cs_n_o,
   output logic              ddr_ras_n_o,
   output logic              ddr_cas_n_o,
   output logic              ddr_we_n_o,
   output logic [BA_W-1:0]   ddr_ba_o,
   output logic [ADDR_W-1:0] ddr_addr_o,
   input  logic              ctrl_en_req_i,
   input  logic              cal_done_i,
   output logic              ctrl_en_o,
   output logic              ready_o
);

   if (SLOTS < 14) begin : g_chk_slots
      $error("SLOTS must hold the 14-entry power-up list");
   end
   if (ADDR_W < 11) begin : g_chk_addr
      $error("ADDR_W must cover address bit 10");
   end
   if (WAIT_W < 8) begin : g_chk_wait
      $error("WAIT_W must hold a 200-cycle wait");
   end
   if (BA_W < 2) begin : g_chk_ba
      $error("BA_W must select four mode registers");
   end

   logic [SLOT_W-1:0] slot [SLOTS];
   logic [SLOTS-1:0]  slot_en;
   pins_t             pins;

   ddr2_init_slots #(
      .SLOTS(SLOTS), .ADDR_W(ADDR_W), .BA_W(BA_W), .WAIT_W(WAIT_W),
      .MR_VAL(MR_VAL), .EMR_VAL(EMR_VAL)
   ) u_slots (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wr_i  (cfg_wr_i),
      .idx_i (cfg_idx_i),
      .data_i(cfg_data_i),
      .slot_o(slot),
      .en_o  (slot_en)
   );

   ddr2_init_fsm #(
      .SLOTS(SLOTS), .ADDR_W(ADDR_W), .BA_W(BA_W), .WAIT_W(WAIT_W)
   ) u_fsm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start_i),
      .slot_i (slot),
      .en_i   (slot_en),
      .busy_o (busy_o),
      .done_o (init_done_o),
      .pins_o (pins),
      .ba_o   (ddr_ba_o),
      .addr_o (ddr_addr_o)
   );

   ddr2_init_gate u_gate (
      .done_i (init_done_o),
      .req_i  (ctrl_en_req_i),
      .cal_i  (cal_done_i),
      .en_o   (ctrl_en_o),
      .ready_o(ready_o)
   );

   assign ddr_cs_n_o  = pins.cs_n;
   assign ddr_ras_n_o = pins.ras_n;
   assign ddr_cas_n_o = pins.cas_n;
   assign ddr_we_n_o  = pins.we_n;

   // R9: the controller can never be enabled while the list is running
   assert_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_en_o |-> !busy_o);

   // R10: ready requires both completed init and calibration
   assert_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |-> (init_done_o && cal_done_i && !busy_o));

endmodule

// File: tb/ddr2_init_seq_test.sv
module ddr2_init_seq_test;

   localparam int SLOTS = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic [28:0] cfg_data = '0;
   logic        start = 1'b0;
   logic        busy, done, cs_n, ras_n, cas_n, we_n;
   logic [2:0]  ba;
   logic [13:0] addr;
   logic        req = 1'b0;
   logic        cal = 1'b0;
   logic        ctrl_en, ready;

   ddr2_init_seq uut (
      .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_idx_i(cfg_idx),
      .cfg_data_i(cfg_data), .start_i(start), .busy_o(busy), .init_done_o(done),
      .ddr_cs_n_o(cs_n), .ddr_ras_n_o(ras_n), .ddr_cas_n_o(cas_n), .ddr_we_n_o(we_n),
      .ddr_ba_o(ba), .ddr_addr_o(addr), .ctrl_en_req_i(req), .cal_done_i(cal),
      .ctrl_en_o(ctrl_en), .ready_o(ready)
   );

   always #4 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int total = 0;
   int fails = 0;
   bit ended = 1'b0;

   // bench mirror of the slot contents it has programmed
   bit          x_en   [SLOTS];
   int          x_op   [SLOTS];
   int          x_ba   [SLOTS];
   int          x_addr [SLOTS];
   int          x_w    [SLOTS];

   task automatic chk(bit ok, string req_tag, string what, int act, int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
      end
   endtask

   task automatic load_defaults();
      int ops [14] = '{0,1,2,2,2,2,1,3,3,3,3,2,2,2};
      int bas [14] = '{0,0,2,3,1,0,0,0,0,0,0,0,1,1};
      int ads [14] = '{0,'h400,0,0,'h004,'h532,'h400,0,0,0,0,'h432,'h384,'h004};
      int ws  [14] = '{106,4,2,2,2,200,4,25,25,25,25,2,2,2};
      for (int i = 0; i < SLOTS; i++) begin
         x_en[i]   = (i < 14);
         x_op[i]   = (i < 14) ? ops[i] : 0;
         x_ba[i]   = (i < 14) ? bas[i] : 0;
         x_addr[i] = (i < 14) ? ads[i] : 0;
         x_w[i]    = (i < 14) ? ws[i]  : 0;
      end
   endtask

   task automatic write_slot(int i, bit en, int op, int b, int a, int w);
      cfg_wr   = 1'b1;
      cfg_idx  = 4'(i);
      cfg_data = {en, 3'(op), 3'(b), 14'(a), 8'(w)};
      @(negedge clk);
      cfg_wr   = 1'b0;
      x_en[i] = en; x_op[i] = op; x_ba[i] = b; x_addr[i] = a; x_w[i] = w;
   endtask

   function automatic int pin_code();
      case ({ras_n, cas_n, we_n})
         3'b010:  return 1;
         3'b000:  return 2;
         3'b001:  return 3;
         default: return 7;
      endcase
   endfunction

   // Start the list at a falling edge, then watch it against the mirror.
   task automatic run_list(string tag, int inj);
      int t0, dur, nexp, nseen, bad_cmd, gate_err, wait_err, done_t;
      int e_t [SLOTS];
      int e_i [SLOTS];
      int s_t [32];
      int s_op [32];
      int s_ba [32];
      int s_a [32];
      bit seen_done;
      req = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t0 = cyc;
      dur = 0; nexp = 0;
      for (int i = 0; i < SLOTS; i++) begin
         if (x_en[i]) begin
            if (x_op[i] != 0) begin
               e_t[nexp] = t0 + dur; e_i[nexp] = i; nexp++;
            end
            dur += x_w[i] + 1;
         end
      end
      nseen = 0; gate_err = 0; wait_err = 0; seen_done = 1'b0; done_t = -1;
      for (int c = 0; c <= dur + 3; c++) begin
         if (!cs_n && {ras_n, cas_n, we_n} != 3'b111 && nseen < 32) begin
            s_t[nseen] = cyc; s_op[nseen] = pin_code();
            s_ba[nseen] = int'(ba); s_a[nseen] = int'(addr); nseen++;
         end
         if (busy && cs_n) wait_err++;
         if (busy && ctrl_en) gate_err++;
         if (done && !seen_done) begin seen_done = 1'b1; done_t = cyc; end
         if (c == inj && inj >= 0) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      chk(nseen == nexp, "R3", {tag, " command count"}, nseen, nexp);
      for (int k = 0; k < nexp && k < nseen; k++) begin
         int i = e_i[k];
         chk(s_t[k] == e_t[k], "R4", {tag, " command cycle"}, s_t[k] - t0, e_t[k] - t0);
         chk(s_op[k] == x_op[i] && s_ba[k] == x_ba[i] && s_a[k] == x_addr[i], "R1",
             {tag, " command fields"}, s_op[k] * 65536 + s_a[k], x_op[i] * 65536 + x_addr[i]);
      end
      chk(done_t == t0 + dur, "R7", {tag, " done cycle"}, done_t - t0, dur);
      chk(wait_err == 0, "R4", {tag, " NOP held during waits"}, wait_err, 0);
      chk(gate_err == 0, "R9", {tag, " enable held off while busy"}, gate_err, 0);
      chk(!busy && cs_n && ras_n && cas_n && we_n && addr == 0, "R12",
          {tag, " idle deselect"}, {cs_n, ras_n, cas_n, we_n}, 15);
   endtask

   initial begin
      bit [31:0] seed = 32'h1234_5678;
      load_defaults();
      req = 1'b1;
      repeat (3) @(negedge clk);
      // R11 reset state and R9/R12 before any run
      chk(!busy && !done, "R11", "reset status", {busy, done}, 0);
      chk(cs_n && ras_n && cas_n && we_n, "R12", "reset pins", {cs_n, ras_n, cas_n, we_n}, 15);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!ctrl_en && !ready, "R9", "enable before init", ctrl_en, 0);

      // R2 power-up list, R6 start timing
      run_list("R2 defaults", -1);
      // R10 ready follows calibration once init is done
      cal = 1'b0;
      @(negedge clk);
      chk(ctrl_en && !ready, "R10", "ready waits on calibration", ready, 0);
      cal = 1'b1;
      @(negedge clk);
      chk(ctrl_en && ready, "R10", "ready after calibration", ready, 1);

      // R8 a start during the default run changes nothing
      run_list("R8 restart ignored", 50);

      // R5 all disabled: done on the next clock
      for (int i = 0; i < SLOTS; i++) write_slot(i, 1'b0, 1, 0, 0, 3);
      run_list("R7 empty list", -1);
      // R5 all enabled with zero wait: back to back
      for (int i = 0; i < SLOTS; i++) write_slot(i, 1'b1, 1 + (i % 3), i % 8, i * 37, 0);
      run_list("R5 zero waits", -1);

      // R1/R4/R5 sweep of programmed lists
      for (int p = 0; p < 24; p++) begin
         for (int i = 0; i < SLOTS; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            write_slot(i, seed[17:16] != 2'b00, 1 + int'(seed[27:20]) % 3,
                       int'(seed[30:28]), int'(seed[13:0]), int'(seed[10:8]) % 6);
         end
         run_list("R1 sweep", (p % 2 == 1) ? 2 : -1);
      end

      // R11 reset during a run restores idle and the power-up list
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      chk(busy, "R6", "busy during run", busy, 1);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!busy && !done && cs_n && ras_n && cas_n && we_n, "R11", "reset mid-run",
          {busy, done, cs_n, ras_n, cas_n, we_n}, 15);
      chk(!ctrl_en && !ready, "R9", "enable after reset", ctrl_en, 0);
      rst_n = 1'b1;
      @(negedge clk);
      load_defaults();
      run_list("R11 defaults restored", -1);

      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule